// File: doc/BRIEF.md
# Customer-Tagged Banked Energy Accumulator

This block keeps an energy ledger next to a shared component such as a memory controller. Each completed bus transaction costs some energy, and that cost goes to the requester that issued the transaction rather than to the component. The requester is named by a customer tag, taken from a user sideband field of the bus or from undecoded high address bits. The tag is an opaque number whose upper field names a core and whose lower field names a virtual context on that core. One component's consumption is therefore split across the cores and contexts that caused it.

The cost of a transaction is computed from three programmable costs: one for each read, one for each write, and one for each byte moved. A static-energy tick charges a fourth programmable cost. Static energy belongs to no requester, so it goes to an anonymous account. A global counter accumulates everything that is charged anywhere. All counters saturate. Software clears counters through a bit mask. Counters marked as locked refuse the clear, and the block flags an error. Any counter can be read back by index.

Counter index 0 is the global total. Indices 1 to NUM_BANKS-1 are the customer banks, addressed by the whole tag value. Index NUM_BANKS is the anonymous account.

Top module: `energy_ledger`

## Requirements
- R1: After synchronous active-low reset, every counter reads zero, all four cost registers are zero (a transaction then adds nothing), and clr_err is low.
- R2: A cycle with cfg_we high loads cfg_data into the cost register chosen by cfg_sel: 0 = read cost, 1 = write cost, 2 = byte cost, 3 = static cost.
- R3: A transaction (txn_valid high for one cycle) charges `(txn_write ? write cost : read cost) + txn_bytes * byte cost`. The charge goes to counter index equal to txn_tag when 1 <= txn_tag < NUM_BANKS. The tag is {core[7:4], context[3:0]}, and the counter updates at the same clock edge.
- R4: A transaction whose tag is 0 (reserved for the global total) or at least NUM_BANKS is charged to the anonymous counter at index NUM_BANKS.
- R5: A cycle with static_tick high adds the static cost to the anonymous counter. A tick and an anonymous transaction in the same cycle both add to it.
- R6: The global counter (index 0) adds every transaction charge and every static charge, whichever account receives them.
- R7: Counters saturate at all ones and never wrap.
- R8: A cycle with clr_req high zeroes, at that edge, each counter whose clr_mask bit is set and which is not locked. A clear wins over an increment to the same counter in the same cycle, and that counter's increment is discarded. Other counters, including the global counter, still take their increments.
- R9: A counter whose bit is set in parameter CLR_LOCK keeps its value when a clear selects it. This is bit 0 (global) by default. clr_err is high for exactly the one cycle after a clear request that selects any locked counter, and low otherwise.
- R10: rd_data shows the counter chosen by rd_idx one clock after rd_idx is presented, and reads zero for an index of NUM_BANKS+1 or higher. global_total always shows counter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Cost register write strobe |
| cfg_sel | input | 2 | Cost register select |
| cfg_data | input | COST_W | Cost value to write |
| txn_valid | input | 1 | One completed transaction this cycle |
| txn_tag | input | CORE_W+CTX_W | Customer tag {core, context} |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_bytes | input | BYTES_W | Bytes moved by the transaction |
| static_tick | input | 1 | Charge one static-energy quantum |
| clr_req | input | 1 | Clear request |
| clr_mask | input | NUM_BANKS+1 | Counters selected for clearing |
| clr_err | output | 1 | Clear touched a locked counter |
| rd_idx | input | IDX_W | Counter index to read |
| rd_data | output | CNT_W | Registered counter value |
| global_total | output | CNT_W | Global counter |

## Verification
Saturation is the hardest state to reach, because a counter of full width never fills in a bench of practical length. The bench therefore builds the block with a narrower counter width and sets the read and byte costs to their maximum. It then repeats maximum-size transactions to one bank until both that bank and the global counter pin at all ones, and it checks that a further charge leaves them there. The clear-versus-increment collision is produced by driving a clear and a transaction to the same bank in one cycle. The check then confirms that the bank reads zero while the global counter still grows.

// File: rtl/energy_pkg.sv
// Package: shared types for the energy ledger.
// Assumes: cost register select is a 2-bit code fixed by the port contract.
package energy_pkg;

    typedef enum logic [1:0] {
        CSEL_READ   = 2'd0,
        CSEL_WRITE  = 2'd1,
        CSEL_BYTE   = 2'd2,
        CSEL_STATIC = 2'd3
    } cost_sel_e;

endpackage

// File: rtl/energy_cfg.sv
// energy_cfg: holds the four programmable energy costs.
// Assumes: one register written per cycle; all costs clear to zero on reset.
module energy_cfg
    import energy_pkg::*;
#(
    parameter int COST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  cost_sel_e         cfg_sel,
    input  logic [COST_W-1:0] cfg_data,
    output logic [COST_W-1:0] rd_cost,
    output logic [COST_W-1:0] wr_cost,
    output logic [COST_W-1:0] byte_cost,
    output logic [COST_W-1:0] static_cost
);

    // Load the selected cost register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cost     <= '0;
            wr_cost     <= '0;
            byte_cost   <= '0;
            static_cost <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                CSEL_READ:   rd_cost     <= cfg_data;
                CSEL_WRITE:  wr_cost     <= cfg_data;
                CSEL_BYTE:   byte_cost   <= cfg_data;
                CSEL_STATIC: static_cost <= cfg_data;
                default:     rd_cost     <= rd_cost;
            endcase
        end
    end

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(rd_cost) && $stable(wr_cost) && $stable(byte_cost) && $stable(static_cost));

endmodule

// File: rtl/energy_cost.sv
// energy_cost: combinational charge of one transaction.
// Assumes: result width is wide enough for the largest cost plus byte product.
module energy_cost #(
    parameter int COST_W  = 16,
    parameter int BYTES_W = 8,
    localparam int INC_W  = COST_W + BYTES_W + 1
) (
    input  logic               txn_write,
    input  logic [BYTES_W-1:0] txn_bytes,
    input  logic [COST_W-1:0]  rd_cost,
    input  logic [COST_W-1:0]  wr_cost,
    input  logic [COST_W-1:0]  byte_cost,
    output logic [INC_W-1:0]   charge
);

    logic [COST_W+BYTES_W-1:0] byte_part;
    logic [COST_W-1:0]         kind_part;

    // Kind cost plus per-byte cost.
    always_comb begin
        kind_part = txn_write ? wr_cost : rd_cost;
        byte_part = (COST_W+BYTES_W)'(txn_bytes) * (COST_W+BYTES_W)'(byte_cost);
        charge    = INC_W'(kind_part) + INC_W'(byte_part);
    end

endmodule

// File: rtl/energy_sat_cnt.sv
// energy_sat_cnt: one saturating accumulator with synchronous clear.
// Assumes: INC_W <= CNT_W; clear has priority over the increment.
module energy_sat_cnt #(
    parameter int CNT_W = 64,
    parameter int INC_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W:0] sum;

    // Widened add exposing the carry.
    always_comb sum = {1'b0, cnt} + (CNT_W+1)'(inc);

    // Clear, else saturating accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (sum[CNT_W]) cnt <= '1;
        else               cnt <= sum[CNT_W-1:0];
    end

    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1) && !clr |=> cnt == '1);
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);

endmodule

// File: rtl/energy_clear.sv
// energy_clear: masks clear requests with the lock set and flags refusals.
// Assumes: error is a one-cycle pulse registered after the request.
module energy_clear #(
    parameter int NUM_CNT = 9,
    parameter logic [NUM_CNT-1:0] LOCK = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_req,
    input  logic [NUM_CNT-1:0] clr_mask,
    output logic [NUM_CNT-1:0] clr_vec,
    output logic               clr_err
);

    // Only unlocked counters receive the clear.
    always_comb clr_vec = clr_req ? (clr_mask & ~LOCK) : '0;

    // Flag a request that named a locked counter.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_err <= 1'b0;
        else        clr_err <= clr_req && |(clr_mask & LOCK);
    end

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |-> $past(clr_req));
    assert_err_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && |(clr_mask & LOCK) |=> clr_err);

endmodule

// File: rtl/energy_ledger.sv
// energy_ledger: per-customer energy accounting beside a shared component.
// Counter 0 = global total, 1..NUM_BANKS-1 = customer banks, NUM_BANKS = anonymous.
// Assumes: CNT_W >= COST_W+BYTES_W+2; txn_valid marks completed transactions.
module energy_ledger #(
    parameter int CORE_W   = 4,
    parameter int CTX_W    = 4,
    parameter int NUM_BANKS = 8,
    parameter int CNT_W    = 64,
    parameter int COST_W   = 16,
    parameter int BYTES_W  = 8,
    parameter logic [NUM_BANKS:0] CLR_LOCK = 1,
    localparam int TAG_W   = CORE_W + CTX_W,
    localparam int NUM_CNT = NUM_BANKS + 1,
    localparam int IDX_W   = $clog2(NUM_CNT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [COST_W-1:0]  cfg_data,
    input  logic               txn_valid,
    input  logic [TAG_W-1:0]   txn_tag,
    input  logic               txn_write,
    input  logic [BYTES_W-1:0] txn_bytes,
    input  logic               static_tick,
    input  logic               clr_req,
    input  logic [NUM_BANKS:0] clr_mask,
    output logic               clr_err,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CNT_W-1:0]   rd_data,
    output logic [CNT_W-1:0]   global_total
);
    import energy_pkg::*;

    localparam int INC_W  = COST_W + BYTES_W + 1;
    localparam int GINC_W = INC_W + 1;
    localparam int ANON   = NUM_BANKS;

    logic [COST_W-1:0]  rd_cost, wr_cost, byte_cost, static_cost;
    logic [INC_W-1:0]   charge;
    logic [NUM_CNT-1:0] clr_vec;
    logic               tag_named;
    logic [GINC_W-1:0]  txn_inc, stat_inc;
    logic [GINC_W-1:0]  inc   [NUM_CNT];
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];
    logic [CNT_W-1:0]   rd_mux;

    energy_cfg #(.COST_W(COST_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cost_sel_e'(cfg_sel)),
        .cfg_data    (cfg_data),
        .rd_cost     (rd_cost),
        .wr_cost     (wr_cost),
        .byte_cost   (byte_cost),
        .static_cost (static_cost)
    );

    energy_cost #(.COST_W(COST_W), .BYTES_W(BYTES_W)) u_cost (
        .txn_write (txn_write),
        .txn_bytes (txn_bytes),
        .rd_cost   (rd_cost),
        .wr_cost   (wr_cost),
        .byte_cost (byte_cost),
        .charge    (charge)
    );

    energy_clear #(.NUM_CNT(NUM_CNT), .LOCK(CLR_LOCK)) u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_req  (clr_req),
        .clr_mask (clr_mask),
        .clr_vec  (clr_vec),
        .clr_err  (clr_err)
    );

    // Classify the tag and form the shared increments.
    always_comb begin
        tag_named = (txn_tag != '0) && (32'(txn_tag) < NUM_BANKS);
        txn_inc   = txn_valid ? GINC_W'(charge) : '0;
        stat_inc  = static_tick ? GINC_W'(static_cost) : '0;
    end

    // One saturating counter per account, increment routed by role.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_acct
        if (i == 0) begin : g_global
            always_comb inc[i] = txn_inc + stat_inc;
        end else if (i == ANON) begin : g_anon
            always_comb inc[i] = (tag_named ? '0 : txn_inc) + stat_inc;
        end else begin : g_bank
            always_comb inc[i] = (32'(txn_tag) == i) ? txn_inc : '0;
        end

        energy_sat_cnt #(.CNT_W(CNT_W), .INC_W(GINC_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_vec[i]),
            .inc   (inc[i]),
            .cnt   (cnt_q[i])
        );
    end

    // Select the requested counter, zero when out of range.
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_CNT; k++)
            if (32'(rd_idx) == k) rd_mux = cnt_q[k];
    end

    // Register the read-back value.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_mux;
    end

    assign global_total = cnt_q[0];

    assert_global_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !clr_vec[0] && (global_total != '1) && (charge != '0) |=> global_total != $past(global_total));
    assert_locked_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req && clr_mask[0] && CLR_LOCK[0] && !txn_valid && !static_tick |=> $stable(global_total));
    assert_read_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == '0) |=> rd_data == $past(global_total));

endmodule

// File: tb/energy_ledger_test.sv
module energy_ledger_test;
    localparam int NB = 8;
    localparam int CW = 28;
    localparam longint MAXV = (64'd1 << CW) - 1;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [15:0] cfg_data = 0;
    logic txn_valid = 0; logic [7:0] txn_tag = 0; logic txn_write = 0; logic [7:0] txn_bytes = 0;
    logic static_tick = 0, clr_req = 0; logic [NB:0] clr_mask = 0;
    logic clr_err; logic [3:0] rd_idx = 0; logic [CW-1:0] rd_data, global_total;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    energy_ledger #(.NUM_BANKS(NB), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .txn_valid(txn_valid), .txn_tag(txn_tag), .txn_write(txn_write), .txn_bytes(txn_bytes),
        .static_tick(static_tick), .clr_req(clr_req), .clr_mask(clr_mask), .clr_err(clr_err),
        .rd_idx(rd_idx), .rd_data(rd_data), .global_total(global_total));

    task automatic check(string req, longint got, longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic rd(input int idx, output longint v);
        rd_idx = idx[3:0];
        @(negedge clk);
        v = longint'(rd_data);
    endtask

    task automatic cfg(input int sel, input int val);
        cfg_we = 1; cfg_sel = sel[1:0]; cfg_data = val[15:0];
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic txn(input int tag, input bit wr, input int bytes, input bit tick);
        txn_valid = 1; txn_tag = tag[7:0]; txn_write = wr; txn_bytes = bytes[7:0]; static_tick = tick;
        @(negedge clk);
        txn_valid = 0; static_tick = 0;
    endtask

    task automatic t_reset();
        longint v;
        check("R1 clr_err", longint'(clr_err), 0);
        for (int i = 0; i < NB + 1; i++) begin rd(i, v); check("R1 counter", v, 0); end
        txn(3, 0, 10, 1);
        rd(3, v); check("R1 zero cost bank", v, 0);
        rd(0, v); check("R1 zero cost global", v, 0);
    endtask

    task automatic t_txn();
        longint v;
        cfg(0, 5); cfg(1, 9); cfg(2, 2); cfg(3, 100);
        txn(8'h03, 0, 4, 0);                       // R2 R3: 5 + 4*2
        rd(3, v); check("R3 read charge bank3", v, 13);
        txn(8'h07, 1, 0, 0);                       // R3: write cost 9
        rd(7, v); check("R3 write charge bank7", v, 9);
        rd(1, v); check("R3 untouched bank1", v, 0);
        rd(0, v); check("R6 global sum", v, 22);
    endtask

    task automatic t_anon();
        longint v;
        txn(8'h00, 0, 1, 0);                       // R4 reserved tag: 7
        txn(8'h12, 1, 3, 0);                       // R4 core1 ctx2 out of range: 15
        rd(NB, v); check("R4 anonymous", v, 22);
        rd(0, v); check("R6 global incl anon", v, 44);
    endtask

    task automatic t_static();
        longint v;
        static_tick = 1; @(negedge clk); static_tick = 0;
        rd(NB, v); check("R5 static tick", v, 122);
        txn(8'h00, 0, 0, 1);                       // R5 tick + anon read
        rd(NB, v); check("R5 tick plus txn", v, 227);
        rd(0, v); check("R6 global incl static", v, 249);
    endtask

    task automatic t_clear();
        longint v;
        clr_req = 1; clr_mask = 9'h008;
        txn(8'h03, 0, 0, 0);                       // R8 collision: clear wins
        clr_req = 0; clr_mask = 0;
        rd(3, v); check("R8 clear wins", v, 0);
        rd(7, v); check("R8 other bank kept", v, 9);
        rd(0, v); check("R8 global still charged", v, 254);
    endtask

    task automatic t_lock();
        longint v;
        clr_req = 1; clr_mask = 9'h181;
        @(negedge clk);
        check("R9 err pulse", longint'(clr_err), 1);
        clr_req = 0; clr_mask = 0;
        @(negedge clk);
        check("R9 err single cycle", longint'(clr_err), 0);
        rd(0, v); check("R9 locked global kept", v, 254);
        rd(7, v); check("R9 unlocked bank7 cleared", v, 0);
        rd(NB, v); check("R9 unlocked anon cleared", v, 0);
        clr_req = 1; clr_mask = 9'h002; @(negedge clk); clr_req = 0; clr_mask = 0;
        check("R9 no err unlocked", longint'(clr_err), 0);
    endtask

    task automatic t_read();
        longint v;
        rd(15, v); check("R10 out of range", v, 0);
        rd(9, v); check("R10 one past anon", v, 0);
        check("R10 global port", longint'(global_total), 254);
    endtask

    task automatic t_sat();
        longint v;
        cfg(0, 65535); cfg(2, 65535);
        for (int i = 0; i < 20; i++) txn(8'h01, 0, 255, 0);
        rd(1, v); check("R7 bank saturates", v, MAXV);
        rd(0, v); check("R7 global saturates", v, MAXV);
        txn(8'h01, 0, 255, 0);
        rd(1, v); check("R7 stays at max", v, MAXV);
        clr_req = 1; clr_mask = 9'h002; @(negedge clk); clr_req = 0; clr_mask = 0;
        rd(1, v); check("R8 clear from max", v, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                t_reset(); t_txn(); t_anon(); t_static();
                t_clear(); t_lock(); t_read(); t_sat();
            end
            begin
                repeat (100000) @(negedge clk);
                checks++; fails++;
                $display("FAIL watchdog got=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule